// File: doc/BRIEF.md
# Serial CRC Generator and Checker for a Byte-Oriented Serial Port

This block keeps two running CRC values beside a serial shifter: one over the bits that leave the device and one over the bits that arrive. Each value advances by one bit whenever the shifter reports a sampled bit on its stream. The feedback polynomial comes from a programmable input. Raising the enable clears both values, so software arms the block immediately before a frame starts.

Software asks for the checksum by pulsing a "send CRC next" request during the last data byte. At the next byte boundary where the transmit buffer is empty, the block signals the shifter to load the transmit CRC in place of a buffer byte. If a buffer byte is still waiting, that byte goes out first and the CRC follows it. While the CRC byte is on the line, both calculators hold their values. The byte received during that slot is gathered and compared with the held receive CRC. A mismatch sets a sticky error flag, and that flag can raise an interrupt request.

Top module: `spi_crc_unit`

## Requirements
- R1: The transmit CRC is advanced only by the transmit bit stream and the receive CRC only by the receive bit stream, so different streams give different values.
- R2: On each strobe while enabled and not in the CRC slot, the CRC becomes {crc[W-2:0],0} XOR (poly if bit XOR crc[W-1] is 1, else 0), with bits fed most significant first.
- R3: A rising edge of `crc_en` clears both CRC values. While `crc_en` is low, strobes leave both values unchanged. Reset clears both values and all flags.
- R4: A `crc_next_set` pulse sets `crc_next`. At a `byte_done` with `crc_next` high, `txbuf_full` low and no CRC slot active, `crc_load` is high in that same cycle, `crc_tx_byte` equals the transmit CRC, and `crc_phase` goes high on the next cycle.
- R5: At a `byte_done` where `txbuf_full` is high, `crc_load` stays low and the request stays pending. The buffered byte then advances the transmit CRC, and the CRC is loaded at the next boundary with the buffer empty.
- R6: Neither CRC value changes while `crc_phase` is high.
- R7: The `byte_done` that ends the CRC slot clears both `crc_next` and `crc_phase`.
- R8: During the CRC slot, received bits are gathered most significant first. At the closing `byte_done`, `crc_err` is set if the gathered byte differs from the receive CRC, and is left clear if they are equal.
- R9: `crc_err` stays set until an `err_clr` pulse. A new mismatch in the same cycle as `err_clr` wins over the clear.
- R10: `irq` is high exactly when `crc_err` and `err_ie` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| crc_en | input | 1 | CRC enable; rising edge clears both CRCs |
| poly | input | CRC_W | Feedback polynomial |
| tx_bit | input | 1 | Transmitted serial bit |
| tx_stb | input | 1 | Sampling strobe for tx_bit |
| rx_bit | input | 1 | Received serial bit |
| rx_stb | input | 1 | Sampling strobe for rx_bit |
| byte_done | input | 1 | One-cycle pulse at each byte boundary |
| txbuf_full | input | 1 | Transmit buffer holds a byte at this boundary |
| crc_next_set | input | 1 | Request that the CRC follow the current byte |
| err_clr | input | 1 | Clears the error flag |
| err_ie | input | 1 | Error interrupt enable |
| crc_load | output | 1 | Shifter loads crc_tx_byte in this cycle |
| crc_tx_byte | output | CRC_W | CRC byte for transmission |
| crc_next | output | 1 | Pending CRC request |
| crc_phase | output | 1 | CRC byte currently on the line |
| tx_crc | output | CRC_W | Transmit CRC value |
| rx_crc | output | CRC_W | Receive CRC value |
| crc_err | output | 1 | Sticky CRC mismatch flag |
| irq | output | 1 | Error interrupt request |

## Verification
The hardest case to reach is the deferred CRC slot. It needs a pending request to meet a boundary with the buffer occupied, then a second boundary with the buffer empty, and after that a received byte that is wrong on purpose. The stimulus reaches it step by step. It raises the request during a data byte, reports the buffer as full at that byte's end, and sends one more data byte with the buffer empty. It then sends a CRC slot whose received byte is the bench's own expected receive CRC with one bit inverted. At each stage the bench compares the CRC values, the load pulse and the loaded byte against a model in the bench.

// File: rtl/spi_crc_pkg.sv
// Package: shared width default and the one-bit CRC step.
// Assumes the polynomial's implicit top term is dropped (W stored bits).
package spi_crc_pkg;
    localparam int CRC_W_DEF = 8;

    // Advance a CRC by one bit: shift left, fold in poly when feedback is 1.
    function automatic logic [CRC_W_DEF-1:0] crc_step(
        input logic [CRC_W_DEF-1:0] cur,
        input logic                 din,
        input logic [CRC_W_DEF-1:0] pol
    );
        logic fb;
        fb = din ^ cur[CRC_W_DEF-1];
        crc_step = {cur[CRC_W_DEF-2:0], 1'b0} ^ (fb ? pol : '0);
    endfunction
endpackage

// File: rtl/spi_crc_lfsr.sv
// Module: spi_crc_lfsr
// One serial CRC register. Clear has priority over advance.
// Assumes W >= 2 and that advance is a single-cycle strobe per bit.
module spi_crc_lfsr #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         advance,
    input  logic         din,
    input  logic [W-1:0] poly,
    output logic [W-1:0] crc
);
    logic fb;
    logic [W-1:0] nxt;

    // Next value of the register for one fed bit.
    always_comb begin
        fb  = din ^ crc[W-1];
        nxt = {crc[W-2:0], 1'b0} ^ (fb ? poly : '0);
    end

    // Register update: reset, clear, or one-bit advance.
    always_ff @(posedge clk) begin
        if (!rst_n)       crc <= '0;
        else if (clear)   crc <= '0;
        else if (advance) crc <= nxt;
    end
endmodule

// File: rtl/spi_crc_ctrl.sv
// Module: spi_crc_ctrl
// Sequences the CRC request: holds the pending request, decides the
// boundary at which the CRC byte replaces a buffer byte, and marks the
// slot in which the CRC is on the line. Assumes byte_done is a one-cycle
// pulse issued after the last bit strobe of a byte.
module spi_crc_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic crc_en,
    input  logic byte_done,
    input  logic txbuf_full,
    input  logic crc_next_set,
    output logic clear,
    output logic crc_load,
    output logic crc_next,
    output logic crc_phase,
    output logic slot_end
);
    logic en_q;

    // Combinational decisions for this cycle.
    always_comb begin
        clear    = crc_en & ~en_q;
        slot_end = crc_phase & byte_done;
        crc_load = crc_en & byte_done & crc_next & ~crc_phase & ~txbuf_full;
    end

    // Previous enable level, used to detect the arming edge.
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= crc_en;
    end

    // Pending request: set by software, dropped when the CRC slot ends.
    always_ff @(posedge clk) begin
        if (!rst_n)            crc_next <= 1'b0;
        else if (!crc_en)      crc_next <= 1'b0;
        else if (slot_end)     crc_next <= 1'b0;
        else if (crc_next_set) crc_next <= 1'b1;
    end

    // CRC slot flag: opens on load, closes at the following boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)        crc_phase <= 1'b0;
        else if (!crc_en)  crc_phase <= 1'b0;
        else if (slot_end) crc_phase <= 1'b0;
        else if (crc_load) crc_phase <= 1'b1;
    end

    // R5
    defer_on_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done && txbuf_full) |-> !crc_load);
    // R7
    slot_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (crc_phase && byte_done) |=> (!crc_phase && !crc_next));
endmodule

// File: rtl/spi_crc_check.sv
// Module: spi_crc_check
// Gathers the received CRC byte during the slot and compares it with the
// held receive CRC at the slot's end. Keeps a sticky error flag.
// Assumes the receive CRC does not move during the slot.
module spi_crc_check #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         crc_phase,
    input  logic         slot_end,
    input  logic         rx_bit,
    input  logic         rx_stb,
    input  logic [W-1:0] rx_crc,
    input  logic         err_clr,
    output logic         crc_err
);
    logic [W-1:0] cap;
    logic         miss;

    // Mismatch at the closing boundary of the slot.
    always_comb miss = slot_end & (cap != rx_crc);

    // Capture register: shifts in received bits, MSB first, during the slot.
    always_ff @(posedge clk) begin
        if (!rst_n)                   cap <= '0;
        else if (crc_phase && rx_stb) cap <= {cap[W-2:0], rx_bit};
    end

    // Sticky error flag: a new mismatch wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       crc_err <= 1'b0;
        else if (miss)    crc_err <= 1'b1;
        else if (err_clr) crc_err <= 1'b0;
    end

    // R8
    err_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(crc_err) |-> $past(crc_phase && slot_end));
    // R9
    err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (crc_err && !err_clr) |=> crc_err);
endmodule

// File: rtl/spi_crc_unit.sv
// Module: spi_crc_unit (top)
// Two serial CRC calculators (index 0 transmit, 1 receive), the request
// sequencer and the received-CRC checker. Assumes the shifter gives one
// strobe per sampled bit and a byte_done pulse after each byte.
module spi_crc_unit #(
    parameter int CRC_W = spi_crc_pkg::CRC_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             crc_en,
    input  logic [CRC_W-1:0] poly,
    input  logic             tx_bit,
    input  logic             tx_stb,
    input  logic             rx_bit,
    input  logic             rx_stb,
    input  logic             byte_done,
    input  logic             txbuf_full,
    input  logic             crc_next_set,
    input  logic             err_clr,
    input  logic             err_ie,
    output logic             crc_load,
    output logic [CRC_W-1:0] crc_tx_byte,
    output logic             crc_next,
    output logic             crc_phase,
    output logic [CRC_W-1:0] tx_crc,
    output logic [CRC_W-1:0] rx_crc,
    output logic             crc_err,
    output logic             irq
);
    localparam int NCH = 2;

    logic             clear;
    logic             slot_end;
    logic [NCH-1:0]   ch_bit;
    logic [NCH-1:0]   ch_stb;
    logic [CRC_W-1:0] ch_crc [NCH];

    // Route the two streams to their own calculators.
    always_comb begin
        ch_bit = {rx_bit, tx_bit};
        ch_stb = {rx_stb, tx_stb};
    end

    spi_crc_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .crc_en       (crc_en),
        .byte_done    (byte_done),
        .txbuf_full   (txbuf_full),
        .crc_next_set (crc_next_set),
        .clear        (clear),
        .crc_load     (crc_load),
        .crc_next     (crc_next),
        .crc_phase    (crc_phase),
        .slot_end     (slot_end)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic adv;
        // Advance only while armed and outside the CRC slot.
        always_comb adv = crc_en & ~crc_phase & ch_stb[g];
        spi_crc_lfsr #(.W(CRC_W)) u_lfsr (
            .clk     (clk),
            .rst_n   (rst_n),
            .clear   (clear),
            .advance (adv),
            .din     (ch_bit[g]),
            .poly    (poly),
            .crc     (ch_crc[g])
        );
    end

    // Expose the values and the byte handed to the shifter.
    always_comb begin
        tx_crc      = ch_crc[0];
        rx_crc      = ch_crc[1];
        crc_tx_byte = ch_crc[0];
        irq         = crc_err & err_ie;
    end

    spi_crc_check #(.W(CRC_W)) u_check (
        .clk       (clk),
        .rst_n     (rst_n),
        .crc_phase (crc_phase),
        .slot_end  (slot_end),
        .rx_bit    (rx_bit),
        .rx_stb    (rx_stb),
        .rx_crc    (rx_crc),
        .err_clr   (err_clr),
        .crc_err   (crc_err)
    );

    // R6
    frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        crc_phase |=> ($stable(tx_crc) && $stable(rx_crc)));
    // R3
    arm_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(crc_en) |=> (tx_crc == '0 && rx_crc == '0));
    // R4
    load_opens_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        crc_load |=> crc_phase);
endmodule

// File: tb/spi_crc_unit_test.sv
module spi_crc_unit_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       crc_en = 1'b0;
    logic [7:0] poly = 8'h07;
    logic       tx_bit = 1'b0, tx_stb = 1'b0, rx_bit = 1'b0, rx_stb = 1'b0;
    logic       byte_done = 1'b0, txbuf_full = 1'b0, crc_next_set = 1'b0;
    logic       err_clr = 1'b0, err_ie = 1'b0;
    logic       crc_load, crc_next, crc_phase, crc_err, irq;
    logic [7:0] crc_tx_byte, tx_crc, rx_crc;

    int checks = 0, errors = 0;
    logic [7:0] m_tx, m_rx, seen_byte, hold_tx, hold_rx;
    logic       seen_load;

    localparam logic [15:0] VEC [6] = '{16'hA5_5A, 16'h00_FF, 16'hF1_F1,
                                        16'h3C_81, 16'h80_01, 16'h7E_E7};

    always #4 clk = ~clk;

    spi_crc_unit uut (
        .clk(clk), .rst_n(rst_n), .crc_en(crc_en), .poly(poly),
        .tx_bit(tx_bit), .tx_stb(tx_stb), .rx_bit(rx_bit), .rx_stb(rx_stb),
        .byte_done(byte_done), .txbuf_full(txbuf_full),
        .crc_next_set(crc_next_set), .err_clr(err_clr), .err_ie(err_ie),
        .crc_load(crc_load), .crc_tx_byte(crc_tx_byte), .crc_next(crc_next),
        .crc_phase(crc_phase), .tx_crc(tx_crc), .rx_crc(rx_crc),
        .crc_err(crc_err), .irq(irq)
    );

    function automatic logic [7:0] model_byte(input logic [7:0] c,
                                              input logic [7:0] d);
        logic [7:0] r;
        r = c;
        for (int i = 7; i >= 0; i--)
            r = {r[6:0], 1'b0} ^ (((d[i] ^ r[7]) == 1'b1) ? poly : 8'h00);
        return r;
    endfunction

    task automatic chk(input logic ok, input string req,
                       input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Send one byte on both streams, then a byte boundary.
    task automatic send(input logic [7:0] t, input logic [7:0] r,
                        input logic full);
        for (int i = 7; i >= 0; i--) begin
            @(negedge clk);
            tx_bit = t[i]; rx_bit = r[i]; tx_stb = 1'b1; rx_stb = 1'b1;
        end
        @(negedge clk);
        tx_stb = 1'b0; rx_stb = 1'b0; byte_done = 1'b1; txbuf_full = full;
        #1;
        seen_load = crc_load; seen_byte = crc_tx_byte;
        @(negedge clk);
        byte_done = 1'b0; txbuf_full = 1'b0;
        #1;
    endtask

    task automatic request();
        @(negedge clk); crc_next_set = 1'b1;
        @(negedge clk); crc_next_set = 1'b0;
        #1;
    endtask

    task automatic rearm();
        @(negedge clk); crc_en = 1'b0;
        @(negedge clk); crc_en = 1'b1;
        @(negedge clk); #1;
        m_tx = 8'h00; m_rx = 8'h00;
    endtask

    initial begin
        #(8 * 100000);
        errors++;
        $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R3 reset state
        chk(tx_crc == 0 && rx_crc == 0, "R3 reset crc", tx_crc, 8'h00);
        chk(!crc_err && !crc_next && !irq && !crc_phase, "R3 reset flags",
            {4'h0, crc_err, crc_next, irq, crc_phase}, 8'h00);

        rearm();
        // Vector table: R1 separate streams, R2 update rule, R4 no load
        foreach (VEC[k]) begin
            send(VEC[k][15:8], VEC[k][7:0], 1'b0);
            m_tx = model_byte(m_tx, VEC[k][15:8]);
            m_rx = model_byte(m_rx, VEC[k][7:0]);
            chk(tx_crc == m_tx, "R2 tx crc", tx_crc, m_tx);
            chk(rx_crc == m_rx, "R1 rx crc", rx_crc, m_rx);
            chk(!seen_load, "R4 no load without request", {7'h0, seen_load}, 8'h00);
        end

        // R3: strobes ignored while disabled, rising enable clears
        hold_tx = tx_crc; hold_rx = rx_crc;
        @(negedge clk); crc_en = 1'b0;
        send(8'h5B, 8'hC3, 1'b0);
        chk(tx_crc == hold_tx, "R3 tx hold when off", tx_crc, hold_tx);
        chk(rx_crc == hold_rx, "R3 rx hold when off", rx_crc, hold_rx);
        @(negedge clk); crc_en = 1'b1;
        @(negedge clk); #1;
        chk(tx_crc == 0 && rx_crc == 0, "R3 arm clears", tx_crc | rx_crc, 8'h00);
        m_tx = 8'h00; m_rx = 8'h00;

        // Matching CRC slot: R4, R6, R7, R8
        send(8'h12, 8'h34, 1'b0);
        m_tx = model_byte(m_tx, 8'h12); m_rx = model_byte(m_rx, 8'h34);
        request();
        chk(crc_next, "R4 request pending", {7'h0, crc_next}, 8'h01);
        send(8'h56, 8'h78, 1'b0);
        m_tx = model_byte(m_tx, 8'h56); m_rx = model_byte(m_rx, 8'h78);
        chk(seen_load, "R4 load pulse", {7'h0, seen_load}, 8'h01);
        chk(seen_byte == m_tx, "R4 loaded byte", seen_byte, m_tx);
        chk(crc_phase, "R4 slot open", {7'h0, crc_phase}, 8'h01);
        send(m_tx, m_rx, 1'b0);
        chk(tx_crc == m_tx, "R6 tx frozen", tx_crc, m_tx);
        chk(rx_crc == m_rx, "R6 rx frozen", rx_crc, m_rx);
        chk(!crc_next && !crc_phase, "R7 slot closed",
            {6'h0, crc_next, crc_phase}, 8'h00);
        chk(!crc_err, "R8 match no error", {7'h0, crc_err}, 8'h00);

        // Deferred slot with mismatch: R5, R8, R10
        rearm();
        err_ie = 1'b1;
        request();
        send(8'hC0, 8'h0C, 1'b1);
        m_tx = model_byte(m_tx, 8'hC0); m_rx = model_byte(m_rx, 8'h0C);
        chk(!seen_load, "R5 deferred while full", {7'h0, seen_load}, 8'h00);
        chk(crc_next && !crc_phase, "R5 still pending",
            {6'h0, crc_next, crc_phase}, 8'h02);
        send(8'hEE, 8'h11, 1'b0);
        m_tx = model_byte(m_tx, 8'hEE); m_rx = model_byte(m_rx, 8'h11);
        chk(tx_crc == m_tx, "R5 buffered byte counted", tx_crc, m_tx);
        chk(seen_load && seen_byte == m_tx, "R5 late load byte", seen_byte, m_tx);
        send(m_tx, m_rx ^ 8'h10, 1'b0);
        chk(crc_err, "R8 mismatch error", {7'h0, crc_err}, 8'h01);
        chk(irq, "R10 irq enabled", {7'h0, irq}, 8'h01);
        @(negedge clk); err_ie = 1'b0; #1;
        chk(!irq, "R10 irq masked", {7'h0, irq}, 8'h00);

        // R9: sticky until cleared
        send(8'h01, 8'h02, 1'b0);
        chk(crc_err, "R9 error sticky", {7'h0, crc_err}, 8'h01);
        @(negedge clk); err_clr = 1'b1;
        @(negedge clk); err_clr = 1'b0; #1;
        chk(!crc_err, "R9 error cleared", {7'h0, crc_err}, 8'h00);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule